// File: doc/BRIEF.md
# Core Module Control and Status Registers

This block is the register bank that a processor core module exposes on a simple 32-bit word-addressed bus. It holds two oscillator settings that can only be changed after an unlock key has been written, a control register, SDRAM and init configuration words, and two flag registers. Each flag register has one address that sets bits and another that clears them. It also holds a free-running reference counter that advances on a tick-enable input, and a read-only window of serial-presence-detect bytes that describes the fitted memory.

The control register drives two outputs. One selects whether boot flash or RAM appears at address zero. The other is a one-cycle reset-request pulse. Reads are combinational from the word address. Unknown addresses read as zero and ignore writes.

Top module: `cmod_sysregs`

## Requirements
- R1: Word 0 reads the identity constant 0x411A3001 and word 4 reads the status constant 0x00100000. Writes to either have no effect.
- R2: A write to word 5 (key register) keeps only data bits [15:0]. A read returns the stored key with bit 16 set when the key equals 0xA05F, and the plain stored key otherwise.
- R3: Writes to word 2 (main oscillator) and word 7 (auxiliary oscillator) take effect only while the key register holds 0xA05F. Otherwise the stored value is unchanged.
- R4: A write to word 3 (control) stores only data bits 0 and 2, and bit 3 always reads back as zero. A control write with data bit 3 set makes `reset_req` high for exactly the one cycle after the write edge.
- R5: `remap_ram` equals control bit 2 (1 means RAM at address zero, 0 means boot flash) and `led_on` equals control bit 0.
- R6: A write to word 12 ORs the data into the volatile flags and a write to word 13 clears the bits that are set in the data. Words 14 and 15 do the same for the non-volatile flags. Words 12 and 14 read the current values, and words 13 and 15 read zero.
- R7: The reference counter at word 10 is 32 bits wide and resets to zero. It increases by one at every clock edge where `ref_tick` is high and holds otherwise.
- R8: Words 64 to 95 return detect-table entry N (equal to the word index) in bits [7:0] with the upper bits zero. Entries 73 to 82 hold the ASCII text "CORE-SDRAM" and every other entry is zero. Words 96 to 127 read zero.
- R9: After reset the registers hold the following values: main oscillator 0x01000048, auxiliary oscillator 0x0007FEFF, init 0x00000112, key 0, control 0, flags 0. SDRAM holds 0x00011122 ORed with a size code: 0x10 for MEM_MB of 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and 0 below that. With the default MEM_MB of 128 this gives 0x0001112E.
- R10: Words 8 (SDRAM) and 9 (init) take any write unconditionally.
- R11: Any other word index reads zero, and a write to it changes no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| ref_tick | input | 1 | Reference-clock enable for the counter |
| remap_ram | output | 1 | RAM at address zero when high |
| led_on | output | 1 | Indicator state |
| reset_req | output | 1 | One-cycle reset request |

## Verification
A single control write can both request a reset and switch the memory at address zero. The bench writes 0x0000000C and checks, one cycle after the write edge, that `reset_req` pulses, that `remap_ram` has risen, and that the control register reads back 0x4. It then checks that the pulse has dropped while the remap setting stays. The counter can also advance in the same cycle that it is being read. The bench holds `ref_tick` high during a read and checks that the value read before the edge is the old count and the value read after it is one higher.

// File: rtl/cmod_pkg.sv
package cmod_pkg;
  localparam logic [31:0] ID_VALUE   = 32'h411A_3001;
  localparam logic [31:0] STAT_VALUE = 32'h0010_0000;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [31:0] OSC_RST    = 32'h0100_0048;
  localparam logic [31:0] AUX_RST    = 32'h0007_FEFF;
  localparam logic [31:0] SDRAM_BASE = 32'h0001_1122;
  localparam logic [31:0] INIT_RST   = 32'h0000_0112;

  localparam int unsigned W_ID     = 0;
  localparam int unsigned W_OSC    = 2;
  localparam int unsigned W_CTRL   = 3;
  localparam int unsigned W_STAT   = 4;
  localparam int unsigned W_KEY    = 5;
  localparam int unsigned W_AUX    = 7;
  localparam int unsigned W_SDRAM  = 8;
  localparam int unsigned W_INIT   = 9;
  localparam int unsigned W_REFCNT = 10;
  localparam int unsigned W_FSET   = 12;
  localparam int unsigned W_FCLR   = 13;
  localparam int unsigned W_NVSET  = 14;
  localparam int unsigned W_NVCLR  = 15;

  localparam int unsigned TAG_FIRST = 73;
  localparam int unsigned TAG_LEN   = 10;
  localparam logic [8*TAG_LEN-1:0] TAG_TEXT = "CORE-SDRAM";

  function automatic logic [31:0] sdram_reset(int unsigned mem_mb);
    logic [31:0] code;
    if (mem_mb >= 256)      code = 32'h10;
    else if (mem_mb >= 128) code = 32'h0C;
    else if (mem_mb >= 64)  code = 32'h08;
    else if (mem_mb >= 32)  code = 32'h04;
    else                    code = 32'h00;
    return SDRAM_BASE | code;
  endfunction

  function automatic logic [31:0] key_view(logic [15:0] key);
    return {15'd0, key == UNLOCK_KEY, key};
  endfunction

  function automatic logic [7:0] spd_entry(int unsigned idx);
    if (idx >= TAG_FIRST && idx < TAG_FIRST + TAG_LEN)
      return TAG_TEXT[8*(TAG_FIRST + TAG_LEN - 1 - idx) +: 8];
    return 8'h00;
  endfunction
endpackage

// File: rtl/cmod_word.sv
module cmod_word #(
  parameter int W = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= wd;
  end
endmodule

// File: rtl/cmod_setclr.sv
module cmod_setclr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  logic [W-1:0] set_mask, clr_mask;
  assign set_mask = set_we ? wd : '0;
  assign clr_mask = clr_we ? wd : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q | set_mask) & ~clr_mask;
  end
endmodule

// File: rtl/cmod_refcnt.sv
module cmod_refcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/cmod_ctrl.sv
module cmod_ctrl
  import cmod_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        wr_key,
  input  logic [31:0] wd,
  output logic [15:0] key_q,
  output logic        unlocked,
  output logic        led_on,
  output logic        remap_ram,
  output logic        reset_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q     <= '0;
      led_on    <= 1'b0;
      remap_ram <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      if (wr_key) key_q <= wd[15:0];
      if (wr_ctrl) begin
        led_on    <= wd[0];
        remap_ram <= wd[2];
      end
      reset_req <= wr_ctrl & wd[3];
    end
  end
  assign unlocked = (key_q == UNLOCK_KEY);
endmodule

// File: rtl/cmod_sysregs.sv
module cmod_sysregs
  import cmod_pkg::*;
#(
  parameter int AW     = 7,
  parameter int MEM_MB = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          ref_tick,
  output logic          remap_ram,
  output logic          led_on,
  output logic          reset_req
);
  localparam int unsigned SPD_FIRST = 2 ** (AW - 1);
  localparam int unsigned SPD_END   = SPD_FIRST + 2 ** (AW - 2);
  localparam logic [31:0] SDRAM_RST = sdram_reset(MEM_MB);

  logic [31:0] idx;
  logic        wr_hit;
  logic        wr_osc, wr_aux, wr_ctrl, wr_key, wr_sdram, wr_init;
  logic        wr_fset, wr_fclr, wr_nvset, wr_nvclr;
  logic        unlocked;
  logic [15:0] key_q;
  logic [31:0] osc_q, aux_q, sdram_q, init_q, flags_q, nvflags_q, refcnt_q;

  assign idx      = 32'(bus_addr);
  assign wr_hit   = bus_sel & bus_wr;
  assign wr_osc   = wr_hit && idx == W_OSC && unlocked;
  assign wr_aux   = wr_hit && idx == W_AUX && unlocked;
  assign wr_ctrl  = wr_hit && idx == W_CTRL;
  assign wr_key   = wr_hit && idx == W_KEY;
  assign wr_sdram = wr_hit && idx == W_SDRAM;
  assign wr_init  = wr_hit && idx == W_INIT;
  assign wr_fset  = wr_hit && idx == W_FSET;
  assign wr_fclr  = wr_hit && idx == W_FCLR;
  assign wr_nvset = wr_hit && idx == W_NVSET;
  assign wr_nvclr = wr_hit && idx == W_NVCLR;

  cmod_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_key(wr_key),
    .wd(bus_wdata), .key_q(key_q), .unlocked(unlocked),
    .led_on(led_on), .remap_ram(remap_ram), .reset_req(reset_req)
  );

  cmod_word #(.W(32), .RST(OSC_RST)) u_osc (
    .clk(clk), .rst_n(rst_n), .we(wr_osc), .wd(bus_wdata), .q(osc_q));
  cmod_word #(.W(32), .RST(AUX_RST)) u_aux (
    .clk(clk), .rst_n(rst_n), .we(wr_aux), .wd(bus_wdata), .q(aux_q));
  cmod_word #(.W(32), .RST(SDRAM_RST)) u_sdram (
    .clk(clk), .rst_n(rst_n), .we(wr_sdram), .wd(bus_wdata), .q(sdram_q));
  cmod_word #(.W(32), .RST(INIT_RST)) u_init (
    .clk(clk), .rst_n(rst_n), .we(wr_init), .wd(bus_wdata), .q(init_q));

  cmod_setclr #(.W(32)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_we(wr_fset), .clr_we(wr_fclr),
    .wd(bus_wdata), .q(flags_q));
  cmod_setclr #(.W(32)) u_nvflags (
    .clk(clk), .rst_n(rst_n), .set_we(wr_nvset), .clr_we(wr_nvclr),
    .wd(bus_wdata), .q(nvflags_q));

  cmod_refcnt #(.W(32)) u_refcnt (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .count(refcnt_q));

  always_comb begin
    bus_rdata = '0;
    if (idx >= SPD_FIRST) begin
      if (idx < SPD_END) bus_rdata = {24'd0, spd_entry(idx)};
    end else begin
      case (idx)
        W_ID:     bus_rdata = ID_VALUE;
        W_OSC:    bus_rdata = osc_q;
        W_CTRL:   bus_rdata = {29'd0, remap_ram, 1'b0, led_on};
        W_STAT:   bus_rdata = STAT_VALUE;
        W_KEY:    bus_rdata = key_view(key_q);
        W_AUX:    bus_rdata = aux_q;
        W_SDRAM:  bus_rdata = sdram_q;
        W_INIT:   bus_rdata = init_q;
        W_REFCNT: bus_rdata = refcnt_q;
        W_FSET:   bus_rdata = flags_q;
        W_NVSET:  bus_rdata = nvflags_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cmod_sysregs_chk.sv
module cmod_sysregs_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          ref_tick,
  input logic          remap_ram,
  input logic          reset_req,
  input logic          unlocked,
  input logic [31:0]   osc_q,
  input logic [31:0]   refcnt_q,
  input logic          wr_ctrl
);
  localparam int unsigned ZERO_FROM = 2 ** (AW - 1) + 2 ** (AW - 2);
  logic rd;
  assign rd = bus_sel & ~bus_wr;

  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && 32'(bus_addr) == 0) |-> bus_rdata == 32'h411A_3001); // R1
  AST_OSC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && 32'(bus_addr) == 2 && !unlocked) |=> $stable(osc_q)); // R3
  AST_CTRL_BIT3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && 32'(bus_addr) == 3) |-> !bus_rdata[3]); // R4
  AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(bus_sel && bus_wr && 32'(bus_addr) == 3 && bus_wdata[3])); // R4
  AST_REMAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(remap_ram)); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(refcnt_q)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> refcnt_q == $past(refcnt_q) + 32'd1); // R7
  AST_SPD_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && 32'(bus_addr) >= ZERO_FROM) |-> bus_rdata == 32'd0); // R8
endmodule

bind cmod_sysregs cmod_sysregs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ref_tick(ref_tick), .remap_ram(remap_ram), .reset_req(reset_req),
  .unlocked(unlocked), .osc_q(osc_q), .refcnt_q(refcnt_q), .wr_ctrl(wr_ctrl)
);

// File: tb/cmod_sysregs_test.sv
module cmod_sysregs_test;
  localparam int PERIOD = 10;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          ref_tick = 1'b0;
  logic          remap_ram, led_on, reset_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  cmod_sysregs #(.AW(AW), .MEM_MB(128)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_tick(ref_tick), .remap_ram(remap_ram), .led_on(led_on),
    .reset_req(reset_req));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string req);
    bus_sel = 1; bus_wr = 0; bus_addr = AW'(a);
    #1;
    check(req, bus_rdata, exp);
    bus_sel = 0;
  endtask

  task automatic t_reset;
    rd(0, 32'h411A_3001, "R1 id");
    rd(4, 32'h0010_0000, "R1 stat");
    rd(2, 32'h0100_0048, "R9 osc");
    rd(7, 32'h0007_FEFF, "R9 aux");
    rd(8, 32'h0001_112E, "R9 sdram");
    rd(9, 32'h0000_0112, "R9 init");
    rd(5, 32'h0, "R9 key");
    rd(3, 32'h0, "R9 ctrl");
    rd(10, 32'h0, "R7 count reset");
    check("R5 remap reset", {31'd0, remap_ram}, 32'd0);
  endtask

  task automatic t_key;
    wr(2, 32'h55);
    rd(2, 32'h0100_0048, "R3 osc locked");
    wr(7, 32'h66);
    rd(7, 32'h0007_FEFF, "R3 aux locked");
    wr(5, 32'h1234_A05F);
    rd(5, 32'h0001_A05F, "R2 unlocked view");
    wr(2, 32'h22);
    rd(2, 32'h22, "R3 osc unlocked");
    wr(7, 32'h77);
    rd(7, 32'h77, "R3 aux unlocked");
    wr(5, 32'hFFFF_0001);
    rd(5, 32'h1, "R2 plain key");
    wr(2, 32'h33);
    rd(2, 32'h22, "R3 relocked");
  endtask

  task automatic t_ctrl;
    wr(3, 32'hFFFF_FFF1);
    rd(3, 32'h1, "R4 only bit0");
    check("R5 led", {31'd0, led_on}, 32'd1);
    check("R4 no pulse", {31'd0, reset_req}, 32'd0);
    wr(3, 32'h0000_000C);
    check("R4 pulse", {31'd0, reset_req}, 32'd1);
    check("R5 remap set", {31'd0, remap_ram}, 32'd1);
    check("R5 led cleared", {31'd0, led_on}, 32'd0);
    rd(3, 32'h4, "R4 bit3 reads 0");
    @(negedge clk);
    check("R4 pulse one cycle", {31'd0, reset_req}, 32'd0);
    check("R5 remap holds", {31'd0, remap_ram}, 32'd1);
    wr(3, 32'h0);
    check("R5 flash back", {31'd0, remap_ram}, 32'd0);
  endtask

  task automatic t_flags;
    wr(12, 32'h0000_00F0);
    wr(12, 32'h0000_0F00);
    rd(12, 32'h0000_0FF0, "R6 flags set");
    wr(13, 32'h0000_0110);
    rd(12, 32'h0000_0EE0, "R6 flags clear");
    rd(13, 32'h0, "R6 clear reads 0");
    wr(14, 32'h8000_0001);
    wr(15, 32'h0000_0001);
    rd(14, 32'h8000_0000, "R6 nvflags");
    rd(15, 32'h0, "R6 nv clear reads 0");
    rd(12, 32'h0000_0EE0, "R6 flags untouched");
  endtask

  task automatic t_cfg;
    wr(8, 32'hDEAD_0001);
    rd(8, 32'hDEAD_0001, "R10 sdram");
    wr(9, 32'h0BAD_F00D);
    rd(9, 32'h0BAD_F00D, "R10 init");
  endtask

  task automatic t_count;
    ref_tick = 1;
    repeat (5) @(negedge clk);
    ref_tick = 0;
    rd(10, 32'd5, "R7 five ticks");
    @(negedge clk);
    rd(10, 32'd5, "R7 hold");
    ref_tick = 1;
    rd(10, 32'd5, "R7 read before edge");
    @(negedge clk);
    ref_tick = 0;
    rd(10, 32'd6, "R7 read after edge");
  endtask

  task automatic t_spd;
    rd(64, 32'h0, "R8 entry 64");
    rd(73, 32'h43, "R8 tag first C");
    rd(77, 32'h2D, "R8 tag dash");
    rd(82, 32'h4D, "R8 tag last M");
    rd(83, 32'h0, "R8 after tag");
    rd(96, 32'h0, "R8 tail zero");
    rd(127, 32'h0, "R8 tail end");
  endtask

  task automatic t_unused;
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h411A_3001, "R1 id ro");
    wr(4, 32'h0);
    rd(4, 32'h0010_0000, "R1 stat ro");
    wr(6, 32'h1234);
    rd(6, 32'h0, "R11 word6");
    wr(11, 32'h5);
    rd(11, 32'h0, "R11 word11");
    wr(20, 32'h1);
    rd(20, 32'h0, "R11 word20");
    wr(33, 32'hFFFF_FFFF);
    rd(33, 32'h0, "R11 word33");
    wr(70, 32'hFF);
    rd(70, 32'h0, "R11 spd ro");
    rd(12, 32'h0000_0EE0, "R11 flags kept");
    rd(8, 32'hDEAD_0001, "R11 sdram kept");
    check("R11 remap kept", {31'd0, remap_ram}, 32'd0);
    check("R11 no pulse", {31'd0, reset_req}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_key();
    t_ctrl();
    t_flags();
    t_cfg();
    t_count();
    t_spd();
    t_unused();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule